// File: doc/BRIEF.md
# Kernel-Call Retire Trace Monitor

This passive block sits beside the retirement port of a MIPS-style core and records kernel-call activity for diagnosis. It never stalls the core, services a call or changes any core state. On each retire it checks whether the retiring instruction is a SYSCALL. If so, it takes the call number from the retiring value of `$v1` and updates two kinds of record.

For each call number in a parameterised watch list, the block keeps three things. It sets a seen flag, and it keeps an occurrence counter that saturates. It also stores a snapshot of the PC and of `$a0`..`$a3`. The snapshot is taken only on the first occurrence of that number.

Separately, the block compares the call number against a parameterised list of numbers that the emulator already services. The first SYSCALL whose number is not on that list is latched once, with its PC and number, behind its own valid flag. A debug harness reads all of this state from plain output ports.

Top module: `kcall_trace_mon`

## Requirements
- R1: A SYSCALL is an instruction word with bits 31:26 equal to 0 and bits 5:0 equal to 0x0C. The code field in bits 25:6 is ignored. Any other word never updates any record.
- R2: While `ret_valid` is low, no record changes, even if `ret_insn` is a SYSCALL.
- R3: Slot i watches call number `WATCH_SET[i*32 +: 32]`. By default, slot 0 watches 0x78 and slot 1 watches 0x12. `watch_seen[i]` rises in the cycle after the first qualifying retire whose `$v1` equals that number.
- R4: Every qualifying retire with a matching `$v1` adds exactly one to that slot's 16-bit count. The count appears one cycle after the retire.
- R5: A count that has reached 0xFFFF stays at 0xFFFF. It never wraps.
- R6: On a slot's first occurrence, the retiring PC and `$a0`..`$a3` are stored. Later occurrences leave the stored values unchanged.
- R7: The default handled list is {0x3C, 0x3D, 0x40, 0x64, 0x78, 0x12}. The first qualifying retire whose `$v1` is not on the list sets `unh_valid` in the next cycle, with `unh_pc` and `unh_num` holding its PC and `$v1`.
- R8: Once `unh_valid` is set, later unhandled calls change nothing. A call whose number is on the handled list never sets `unh_valid`.
- R9: A synchronous active-high `rst` clears every seen flag, count and snapshot, and clears `unh_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid | input | 1 | Retire strobe |
| ret_insn | input | 32 | Retiring instruction word |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_v1 | input | XLEN | `$v1` at retire (call number) |
| ret_a0 | input | XLEN | `$a0` at retire |
| ret_a1 | input | XLEN | `$a1` at retire |
| ret_a2 | input | XLEN | `$a2` at retire |
| ret_a3 | input | XLEN | `$a3` at retire |
| watch_seen | output | N_WATCH | Per-slot seen flag |
| watch_count | output | N_WATCH*CNT_W | Per-slot count, slot i at [i*CNT_W +: CNT_W] |
| watch_pc | output | N_WATCH*XLEN | First-occurrence PC per slot |
| watch_a0 | output | N_WATCH*XLEN | First-occurrence `$a0` per slot |
| watch_a1 | output | N_WATCH*XLEN | First-occurrence `$a1` per slot |
| watch_a2 | output | N_WATCH*XLEN | First-occurrence `$a2` per slot |
| watch_a3 | output | N_WATCH*XLEN | First-occurrence `$a3` per slot |
| unh_valid | output | 1 | First-unhandled record is valid |
| unh_pc | output | XLEN | PC of the first unhandled call |
| unh_num | output | XLEN | Call number of the first unhandled call |

## Verification
On every clock, the assertions check the following per-cycle rules:
- a count steps by exactly one on a hit;
- a count holds at its ceiling;
- a snapshot is frozen once seen;
- the first-unhandled record is sticky;
- a low strobe leaves every record alone.

Only the bench's scenarios can show the rest. That covers which slot a given `$v1` reaches, that instruction words differing from SYSCALL only in opcode or function bits are rejected, and that the handled list keeps 0x3C from latching while 0x16 latches. It also covers that a long run of hits ends exactly at 0xFFFF, and that reset wipes a populated state.

// File: rtl/kcall_pkg.sv
package kcall_pkg;
   localparam int unsigned INSN_W = 32;
   // opcode bits 31:26 and function bits 5:0 take part; code field is masked
   localparam logic [INSN_W-1:0] SYSCALL_MASK  = 32'hFC00_003F;
   localparam logic [INSN_W-1:0] SYSCALL_MATCH = 32'h0000_000C;

   function automatic logic is_syscall(input logic [INSN_W-1:0] insn);
      return (insn & SYSCALL_MASK) == SYSCALL_MATCH;
   endfunction
endpackage

// File: rtl/kcall_decode.sv
module kcall_decode
   import kcall_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned N_HANDLED = 6,
   parameter logic [(N_HANDLED > 0 ? N_HANDLED : 1)*XLEN-1:0] HANDLED_SET = '0
) (
   input  logic              ret_valid,
   input  logic [INSN_W-1:0] ret_insn,
   input  logic [XLEN-1:0]   ret_v1,
   output logic              ev,
   output logic              handled
);
   assign ev = ret_valid && is_syscall(ret_insn);

   generate
      if (N_HANDLED == 0) begin : g_none
         assign handled = 1'b0;
      end else begin : g_list
         logic [N_HANDLED-1:0] hit_vec;
         for (genvar i = 0; i < N_HANDLED; i++) begin : g_cmp
            assign hit_vec[i] = (ret_v1 == HANDLED_SET[i*XLEN +: XLEN]);
         end
         assign handled = |hit_vec;
      end
   endgenerate
endmodule

// File: rtl/kcall_watch_slot.sv
module kcall_watch_slot #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned CNT_W = 16,
   parameter logic [XLEN-1:0] WATCH_NUM = '0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ev,
   input  logic [XLEN-1:0]      ret_v1,
   input  logic [XLEN-1:0]      ret_pc,
   input  logic [3:0][XLEN-1:0] ret_arg,
   output logic                 seen,
   output logic [CNT_W-1:0]     count,
   output logic [XLEN-1:0]      snap_pc,
   output logic [3:0][XLEN-1:0] snap_arg
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic hit;
   assign hit = ev && (ret_v1 == WATCH_NUM);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen     <= 1'b0;
         count    <= '0;
         snap_pc  <= '0;
         snap_arg <= '0;
      end else if (hit) begin
         seen <= 1'b1;
         if (!seen) begin
            snap_pc  <= ret_pc;
            snap_arg <= ret_arg;
         end
         if (count != CNT_MAX) count <= count + 1'b1;
      end
   end

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1));
   // R5
   count_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (count == CNT_MAX) |=> count == CNT_MAX);
   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
      seen |=> ($stable(snap_pc) && $stable(snap_arg)));
   // R3
   seen_rise_chk: assert property (@(posedge clk) disable iff (rst)
      hit |=> seen);
endmodule

// File: rtl/kcall_first_unhandled.sv
module kcall_first_unhandled #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ev,
   input  logic            handled,
   input  logic [XLEN-1:0] ret_pc,
   input  logic [XLEN-1:0] ret_v1,
   output logic            valid,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] num
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         pc    <= '0;
         num   <= '0;
      end else if (ev && !handled && !valid) begin
         valid <= 1'b1;
         pc    <= ret_pc;
         num   <= ret_v1;
      end
   end

   // R7
   unh_take_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid && ev && !handled) |=> (valid && num == $past(ret_v1) && pc == $past(ret_pc)));
   // R8
   unh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      valid |=> (valid && $stable(pc) && $stable(num)));
endmodule

// File: rtl/kcall_trace_mon.sv
module kcall_trace_mon
   import kcall_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_HANDLED = 6,
   parameter logic [(N_HANDLED > 0 ? N_HANDLED : 1)*XLEN-1:0] HANDLED_SET =
      {32'h12, 32'h78, 32'h64, 32'h40, 32'h3D, 32'h3C},
   parameter int unsigned N_WATCH = 2,
   parameter logic [N_WATCH*XLEN-1:0] WATCH_SET = {32'h12, 32'h78}
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      ret_valid,
   input  logic [INSN_W-1:0]         ret_insn,
   input  logic [XLEN-1:0]           ret_pc,
   input  logic [XLEN-1:0]           ret_v1,
   input  logic [XLEN-1:0]           ret_a0,
   input  logic [XLEN-1:0]           ret_a1,
   input  logic [XLEN-1:0]           ret_a2,
   input  logic [XLEN-1:0]           ret_a3,
   output logic [N_WATCH-1:0]        watch_seen,
   output logic [N_WATCH*CNT_W-1:0]  watch_count,
   output logic [N_WATCH*XLEN-1:0]   watch_pc,
   output logic [N_WATCH*XLEN-1:0]   watch_a0,
   output logic [N_WATCH*XLEN-1:0]   watch_a1,
   output logic [N_WATCH*XLEN-1:0]   watch_a2,
   output logic [N_WATCH*XLEN-1:0]   watch_a3,
   output logic                      unh_valid,
   output logic [XLEN-1:0]           unh_pc,
   output logic [XLEN-1:0]           unh_num
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("kcall_trace_mon: XLEN must be at least 8");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("kcall_trace_mon: CNT_W must be at least 2");
      end
      if (N_WATCH < 1) begin : g_bad_watch
         $error("kcall_trace_mon: N_WATCH must be at least 1");
      end
   endgenerate

   logic ev;
   logic handled;
   logic [3:0][XLEN-1:0] ret_arg;
   assign ret_arg = {ret_a3, ret_a2, ret_a1, ret_a0};

   kcall_decode #(
      .XLEN(XLEN), .N_HANDLED(N_HANDLED), .HANDLED_SET(HANDLED_SET)
   ) u_decode (
      .ret_valid(ret_valid), .ret_insn(ret_insn), .ret_v1(ret_v1),
      .ev(ev), .handled(handled)
   );

   generate
      for (genvar s = 0; s < N_WATCH; s++) begin : g_slot
         logic [3:0][XLEN-1:0] snap_arg;
         kcall_watch_slot #(
            .XLEN(XLEN), .CNT_W(CNT_W), .WATCH_NUM(WATCH_SET[s*XLEN +: XLEN])
         ) u_slot (
            .clk(clk), .rst(rst), .ev(ev), .ret_v1(ret_v1), .ret_pc(ret_pc),
            .ret_arg(ret_arg),
            .seen(watch_seen[s]),
            .count(watch_count[s*CNT_W +: CNT_W]),
            .snap_pc(watch_pc[s*XLEN +: XLEN]),
            .snap_arg(snap_arg)
         );
         assign watch_a0[s*XLEN +: XLEN] = snap_arg[0];
         assign watch_a1[s*XLEN +: XLEN] = snap_arg[1];
         assign watch_a2[s*XLEN +: XLEN] = snap_arg[2];
         assign watch_a3[s*XLEN +: XLEN] = snap_arg[3];
      end
   endgenerate

   kcall_first_unhandled #(.XLEN(XLEN)) u_unh (
      .clk(clk), .rst(rst), .ev(ev), .handled(handled),
      .ret_pc(ret_pc), .ret_v1(ret_v1),
      .valid(unh_valid), .pc(unh_pc), .num(unh_num)
   );

   // R2
   strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !ret_valid |=> ($stable(watch_count) && $stable(watch_seen) && $stable(unh_valid)));
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (watch_seen == '0 && watch_count == '0 && !unh_valid));
endmodule

// File: tb/kcall_trace_mon_bench.sv
module kcall_trace_mon_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ret_valid = 1'b0;
   logic [31:0] ret_insn = '0, ret_pc = '0, ret_v1 = '0;
   logic [31:0] ret_a0 = '0, ret_a1 = '0, ret_a2 = '0, ret_a3 = '0;
   logic [1:0]  watch_seen;
   logic [31:0] watch_count;
   logic [63:0] watch_pc, watch_a0, watch_a1, watch_a2, watch_a3;
   logic        unh_valid;
   logic [31:0] unh_pc, unh_num;

   always #5 clk = ~clk;

   kcall_trace_mon u_kcall_trace_mon (
      .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_insn(ret_insn),
      .ret_pc(ret_pc), .ret_v1(ret_v1), .ret_a0(ret_a0), .ret_a1(ret_a1),
      .ret_a2(ret_a2), .ret_a3(ret_a3), .watch_seen(watch_seen),
      .watch_count(watch_count), .watch_pc(watch_pc), .watch_a0(watch_a0),
      .watch_a1(watch_a1), .watch_a2(watch_a2), .watch_a3(watch_a3),
      .unh_valid(unh_valid), .unh_pc(unh_pc), .unh_num(unh_num)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural reference model
   int unsigned handled_q[$] = '{32'h3C, 32'h3D, 32'h40, 32'h64, 32'h78, 32'h12};
   int unsigned watch_q[$]   = '{32'h78, 32'h12};
   bit          m_seen[2];
   int          m_cnt[2];
   logic [31:0] m_pc[2], m_a0[2], m_a1[2], m_a2[2], m_a3[2];
   bit          m_uv;
   logic [31:0] m_upc, m_unum;

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 2; i++) begin
            m_seen[i] = 0; m_cnt[i] = 0;
            m_pc[i] = 0; m_a0[i] = 0; m_a1[i] = 0; m_a2[i] = 0; m_a3[i] = 0;
         end
         m_uv = 0; m_upc = 0; m_unum = 0;
      end else if (ret_valid && ret_insn[31:26] == 6'd0 && ret_insn[5:0] == 6'h0C) begin
         bit known;
         known = 0;
         foreach (handled_q[k]) if (handled_q[k] == ret_v1) known = 1;
         for (int i = 0; i < 2; i++) begin
            if (watch_q[i] == ret_v1) begin
               if (!m_seen[i]) begin
                  m_pc[i] = ret_pc; m_a0[i] = ret_a0; m_a1[i] = ret_a1;
                  m_a2[i] = ret_a2; m_a3[i] = ret_a3;
               end
               m_seen[i] = 1;
               if (m_cnt[i] < 65535) m_cnt[i] = m_cnt[i] + 1;
            end
         end
         if (!known && !m_uv) begin
            m_uv = 1; m_upc = ret_pc; m_unum = ret_v1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model (R3 R4 R6 R7 R8)
   always @(negedge clk) begin
      if (!rst && !done) begin
         for (int i = 0; i < 2; i++) begin
            chk(watch_seen[i] == m_seen[i], "R3 seen", 64'(watch_seen[i]), 64'(m_seen[i]));
            chk(watch_count[i*16 +: 16] == 16'(m_cnt[i]), "R4 count",
                64'(watch_count[i*16 +: 16]), 64'(m_cnt[i]));
            chk(watch_pc[i*32 +: 32] == m_pc[i] && watch_a0[i*32 +: 32] == m_a0[i] &&
                watch_a1[i*32 +: 32] == m_a1[i] && watch_a2[i*32 +: 32] == m_a2[i] &&
                watch_a3[i*32 +: 32] == m_a3[i], "R6 snapshot",
                64'(watch_pc[i*32 +: 32]), 64'(m_pc[i]));
         end
         chk(unh_valid == m_uv && unh_pc == m_upc && unh_num == m_unum, "R7 R8 unhandled",
             {unh_pc, unh_num}, {m_upc, m_unum});
      end
   end

   function automatic logic [31:0] sc(input logic [19:0] code);
      return {6'd0, code, 6'h0C};
   endfunction

   task automatic drive(input bit v, input logic [31:0] insn, input logic [31:0] pc,
                        input logic [31:0] v1, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic [31:0] a3);
      @(negedge clk);
      ret_valid = v; ret_insn = insn; ret_pc = pc; ret_v1 = v1;
      ret_a0 = a0; ret_a1 = a1; ret_a2 = a2; ret_a3 = a3;
      @(negedge clk);
      ret_valid = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(watch_seen == 0 && watch_count == 0 && !unh_valid, "R9 reset state",
          {31'd0, unh_valid, watch_count}, 64'd0);
      rst = 0;
      // R1 non-syscall encodings with a watched number
      drive(1, 32'h8C00_000C, 32'h100, 32'h78, 1, 2, 3, 4);
      drive(1, 32'h0000_000D, 32'h104, 32'h78, 1, 2, 3, 4);
      chk(watch_count[15:0] == 0 && !unh_valid, "R1 non-syscall ignored",
          64'(watch_count[15:0]), 64'd0);
      // R2 strobe low
      drive(0, sc(0), 32'h108, 32'h78, 1, 2, 3, 4);
      drive(0, sc(0), 32'h10C, 32'h99, 1, 2, 3, 4);
      chk(watch_seen == 0 && !unh_valid, "R2 strobe low ignored", 64'(watch_seen), 64'd0);
      // R1 R3 R6 first 0x78 with non-zero code field
      drive(1, sc(20'hABCDE), 32'h0011_2A00, 32'h78, 32'h5, 32'h0011_2AB0, 32'h0, 32'h0013_28C0);
      chk(watch_seen == 2'b01, "R3 first 0x78 seen", 64'(watch_seen), 64'd1);
      chk(watch_pc[31:0] == 32'h0011_2A00 && watch_a3[31:0] == 32'h0013_28C0,
          "R6 first snapshot", 64'(watch_pc[31:0]), 64'h0011_2A00);
      // R4 R6 second 0x78
      drive(1, sc(0), 32'h0011_2B00, 32'h78, 9, 9, 9, 9);
      chk(watch_count[15:0] == 2, "R4 second count", 64'(watch_count[15:0]), 64'd2);
      chk(watch_a0[31:0] == 32'h5, "R6 not overwritten", 64'(watch_a0[31:0]), 64'h5);
      // R8 handled-unwatched does not latch
      drive(1, sc(0), 32'h200, 32'h3C, 0, 0, 0, 0);
      chk(!unh_valid, "R8 handled 0x3C", 64'(unh_valid), 64'd0);
      // R3 slot 1
      drive(1, sc(0), 32'h0011_2A54, 32'h12, 32'h5, 32'h0011_2AB0, 32'h0, 32'h0013_28C0);
      chk(watch_seen == 2'b11 && watch_count[31:16] == 1, "R3 slot1 0x12",
          64'(watch_count[31:16]), 64'd1);
      // R7 first unhandled
      drive(1, sc(0), 32'h0011_2A74, 32'h16, 32'h5, 32'h0011_2AB0, 32'h0, 32'h0013_28C0);
      chk(unh_valid && unh_pc == 32'h0011_2A74 && unh_num == 32'h16, "R7 first unhandled",
          {unh_pc, unh_num}, {32'h0011_2A74, 32'h16});
      // R8 later unhandled ignored
      drive(1, sc(0), 32'h300, 32'h20, 0, 0, 0, 0);
      chk(unh_num == 32'h16 && unh_pc == 32'h0011_2A74, "R8 sticky", 64'(unh_num), 64'h16);
      // R5 saturation
      @(negedge clk);
      ret_valid = 1; ret_insn = sc(0); ret_v1 = 32'h78; ret_pc = 32'h400;
      repeat (65540) @(negedge clk);
      ret_valid = 0;
      @(negedge clk);
      chk(watch_count[15:0] == 16'hFFFF, "R5 saturate", 64'(watch_count[15:0]), 64'hFFFF);
      // R9 reset clears populated state
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      chk(watch_seen == 0 && watch_count == 0 && watch_pc == 0 && !unh_valid,
          "R9 reset clears", 64'(watch_count), 64'd0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule